// File: doc/BRIEF.md
# Dual-Tone Melody Note Sequencer

This block plays short tunes held in a dedicated note memory of up to 1024 words, each 22 bits wide. A host picks a song number from 1 to 31, sets a tempo, and pulses `play_i`. The sequencer first reads a song table from the bottom of the same memory to find where that song begins. It then walks the note words one after another. For each note it loads two pitch dividers and one duration counter. The duration is the note's beat code scaled by the live tempo setting. It stops after the note that carries the end-of-song flag.

Two square-wave tone outputs are produced at the same time, one per pitch field. Either can be silenced by a pitch code of zero. A busy flag tells the host how far playback has got. With the mode input low, busy marks each note separately. With it high, busy covers the whole song. The note memory sits outside the block behind a plain synchronous read port: the address and read enable are registered, and the data returns on the cycle after the read is sampled.

Top module: `melody_seq`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `tone_a_o`, `tone_b_o` and `mem_rd_en_o` are 0.
- R2: A play pulse with song number s (1..31) issues a one-cycle read of address s. Bits [9:0] of that word give the address of the song's first note. Later notes are read from consecutive addresses.
- R3: A note word holds the tone A pitch code in bits [21:16], the tone B pitch code in bits [15:10], the beat code in bits [9:7] and the end-of-song flag in bit 6. Bits [5:0] are ignored.
- R4: A note lasts units × (tempo + 1) × TICK_PER_UNIT clock cycles, with TICK_PER_UNIT defaulting to 4. The units come from the beat code: 0→1, 1→2, 2→3, 3→4, 4→6, 5→8. Codes 6 and 7 also give 8.
- R5: A tone with pitch code c in 1..41 toggles every PITCH_STEP × (42 − c) cycles of its note, with PITCH_STEP defaulting to 2. Codes above 41 play as 41, and code 0 leaves that tone at 0. Each note starts with both tones at 0.
- R6: With `busy_mode_i` = 0, `busy_o` is high for exactly the duration of each note and low for exactly one cycle between consecutive notes of a song.
- R7: With `busy_mode_i` = 1, `busy_o` rises the cycle after the play pulse and stays high until the end-of-song note finishes. That is 4 + ΣD + (n − 1) cycles for n notes of durations D.
- R8: A play pulse with song number 0 is ignored: no read is issued and `busy_o` stays low.
- R9: A play pulse with a nonzero song number while a song is in progress abandons it and restarts at the newly selected song.
- R10: Whenever `busy_o` is low, both tone outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| play_i | input | 1 | One-cycle request to start the selected song |
| song_i | input | 5 | Song number, 1..31 valid, 0 ignored |
| tempo_i | input | 4 | Tempo scale, sampled at every note load |
| busy_mode_i | input | 1 | 0: busy per note, 1: busy per song |
| mem_rd_en_o | output | 1 | Note memory read enable |
| mem_addr_o | output | 10 | Note memory read address |
| mem_rdata_i | input | 22 | Note memory read data, valid one cycle after the read |
| tone_a_o | output | 1 | First square-wave tone |
| tone_b_o | output | 1 | Second square-wave tone |
| busy_o | output | 1 | Busy flag, meaning set by `busy_mode_i` |

## Verification
Four songs cover the playback patterns. One mixes the lowest pitch, the highest pitch, a silent tone and a clamped pitch code. One starts with a doubly silent note that has an out-of-range beat code. One sits at song number 31 near the top of memory. One is a single note at the largest tempo. Between them they separate errors in the field positions, the beat-unit mapping, the tempo scaling and the pitch reload. Per-note windows measure each duration and toggle count against values computed from the note words. Per-song windows measure the whole span with its fetch overhead, which shows whether the one-cycle inter-note gap and the song-table lookup latency are correct. A mid-note restart and a song-zero request check that the control logic lets the newest valid request win and that an invalid one is ignored.

// File: rtl/melody_pkg.sv
// Shared constants, state encoding and helper functions for the melody
// sequencer. Assumes the fixed 22-bit note word layout given in the brief.
package melody_pkg;

    localparam int NOTE_W    = 22;
    localparam int PITCH_W   = 6;
    localparam int BEAT_W    = 3;
    localparam int A_LSB     = 16;
    localparam int B_LSB     = 10;
    localparam int BEAT_LSB  = 7;
    localparam int EOS_BIT   = 6;
    localparam int TOP_PITCH = 41;   // number of playable semitones
    localparam int MAX_UNITS = 8;    // largest beat multiple

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SONG_REQ,
        ST_SONG_DAT,
        ST_NOTE_REQ,
        ST_NOTE_DAT,
        ST_PLAY
    } seq_state_t;

    // Beat code to number of tempo units; reserved codes saturate.
    function automatic int unsigned beat_units(input logic [BEAT_W-1:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 3;
            3'd3:    return 4;
            3'd4:    return 6;
            default: return MAX_UNITS;
        endcase
    endfunction

    // Pitch code to divider reload (toggle interval); 0 means silent.
    function automatic int unsigned pitch_reload(input logic [PITCH_W-1:0] code,
                                                 input int unsigned step);
        int unsigned c;
        if (code == '0) return 0;
        c = (int'(code) > TOP_PITCH) ? TOP_PITCH : int'(code);
        return step * (TOP_PITCH + 1 - c);
    endfunction

endpackage

// File: rtl/mel_tone_gen.sv
// Square-wave divider for one tone channel. A load pulse stores the toggle
// interval and clears the output; while run_i is high the output flips each
// time the down-counter passes zero. Interval 0 keeps the channel silent.
// The output is gated low whenever run_i is low.
module mel_tone_gen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DIV_W-1:0] reload_i,
    input  logic             run_i,
    output logic             tone_o
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] period_q;
    logic             tone_q;

    // Divider counter and toggle flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            period_q <= '0;
            tone_q   <= 1'b0;
        end else if (load_i) begin
            period_q <= reload_i;
            cnt_q    <= reload_i - 1'b1;
            tone_q   <= 1'b0;
        end else if (run_i && (period_q != '0)) begin
            if (cnt_q == '0) begin
                cnt_q  <= period_q - 1'b1;
                tone_q <= ~tone_q;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign tone_o = tone_q & run_i;

endmodule

// File: rtl/mel_beat_timer.sv
// Note duration counter. Loaded with a duration D (at least 2), it counts
// down while run_i is high and flags the next-to-last and last cycles.
module mel_beat_timer #(
    parameter int DUR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DUR_W-1:0] dur_i,
    input  logic             run_i,
    output logic             near_end_o,
    output logic             last_o
);

    logic [DUR_W-1:0] cnt_q;

    // Remaining-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= dur_i - 1'b1;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign near_end_o = (cnt_q == DUR_W'(1));
    assign last_o     = (cnt_q == '0);

endmodule

// File: rtl/mel_seq_ctrl.sv
// Playback controller. It looks up the song start in the table, fetches
// notes one by one, and prefetches the next note during the second-to-last
// cycle of the current one, so that only one fetch cycle separates notes.
// Assumes a memory with a registered read port and one cycle of latency.
module mel_seq_ctrl
    import melody_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int SONG_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              play_i,
    input  logic [SONG_W-1:0] song_i,
    input  logic              busy_mode_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic              eos_i,
    input  logic              near_end_i,
    input  logic              last_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              load_o,
    output logic              playing_o,
    output logic              busy_o
);

    seq_state_t state_q;
    logic       eos_q;
    logic       start;

    assign start = play_i && (song_i != '0);

    // Sequencing state, read requests and end-of-song latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_en_o <= 1'b0;
            addr_o  <= '0;
            eos_q   <= 1'b0;
        end else begin
            rd_en_o <= 1'b0;
            if (start) begin
                state_q <= ST_SONG_REQ;
                rd_en_o <= 1'b1;
                addr_o  <= ADDR_W'(song_i);
            end else begin
                case (state_q)
                    ST_SONG_REQ: state_q <= ST_SONG_DAT;
                    ST_SONG_DAT: begin
                        addr_o  <= ptr_i;
                        rd_en_o <= 1'b1;
                        state_q <= ST_NOTE_REQ;
                    end
                    ST_NOTE_REQ: state_q <= ST_NOTE_DAT;
                    ST_NOTE_DAT: begin
                        eos_q   <= eos_i;
                        state_q <= ST_PLAY;
                    end
                    ST_PLAY: begin
                        if (!eos_q && near_end_i) begin
                            rd_en_o <= 1'b1;
                            addr_o  <= addr_o + 1'b1;
                        end
                        if (last_i) begin
                            state_q <= eos_q ? ST_IDLE : ST_NOTE_DAT;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign load_o    = (state_q == ST_NOTE_DAT) && !start;
    assign playing_o = (state_q == ST_PLAY);
    assign busy_o    = busy_mode_i ? (state_q != ST_IDLE) : playing_o;

endmodule

// File: rtl/melody_seq.sv
// Dual-tone melody sequencer top. It decodes the note word returned by the
// external note memory, turns beat and tempo into a duration, and drives the
// two tone channels from a computed divider mapping.
// Assumes TICK_PER_UNIT >= 2, so that every note lasts at least two cycles.
module melody_seq
    import melody_pkg::*;
#(
    parameter int ADDR_W        = 10,
    parameter int SONG_W        = 5,
    parameter int TEMPO_W       = 4,
    parameter int TICK_PER_UNIT = 4,
    parameter int PITCH_STEP    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               play_i,
    input  logic [SONG_W-1:0]  song_i,
    input  logic [TEMPO_W-1:0] tempo_i,
    input  logic               busy_mode_i,
    output logic               mem_rd_en_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    input  logic [NOTE_W-1:0]  mem_rdata_i,
    output logic               tone_a_o,
    output logic               tone_b_o,
    output logic               busy_o
);

    localparam int MAX_DUR = MAX_UNITS * (2 ** TEMPO_W) * TICK_PER_UNIT;
    localparam int DUR_W   = $clog2(MAX_DUR + 1);
    localparam int DIV_W   = $clog2(PITCH_STEP * TOP_PITCH + 1);

    logic [1:0][PITCH_W-1:0] pitch_code;
    logic [1:0][DIV_W-1:0]   reload;
    logic [1:0]              tone_vec;
    logic [BEAT_W-1:0]       beat_code;
    logic [DUR_W-1:0]        note_dur;
    logic                    load, playing, near_end, last;

    assign pitch_code[0] = mem_rdata_i[A_LSB +: PITCH_W];
    assign pitch_code[1] = mem_rdata_i[B_LSB +: PITCH_W];
    assign beat_code     = mem_rdata_i[BEAT_LSB +: BEAT_W];

    // Duration in clock cycles from beat code and tempo.
    always_comb begin
        note_dur = DUR_W'(beat_units(beat_code) * (int'(tempo_i) + 1) * TICK_PER_UNIT);
    end

    mel_seq_ctrl #(
        .ADDR_W (ADDR_W),
        .SONG_W (SONG_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .play_i      (play_i),
        .song_i      (song_i),
        .busy_mode_i (busy_mode_i),
        .ptr_i       (mem_rdata_i[ADDR_W-1:0]),
        .eos_i       (mem_rdata_i[EOS_BIT]),
        .near_end_i  (near_end),
        .last_i      (last),
        .rd_en_o     (mem_rd_en_o),
        .addr_o      (mem_addr_o),
        .load_o      (load),
        .playing_o   (playing),
        .busy_o      (busy_o)
    );

    mel_beat_timer #(
        .DUR_W (DUR_W)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .dur_i      (note_dur),
        .run_i      (playing),
        .near_end_o (near_end),
        .last_o     (last)
    );

    for (genvar g = 0; g < 2; g++) begin : g_chan
        assign reload[g] = DIV_W'(pitch_reload(pitch_code[g], PITCH_STEP));

        mel_tone_gen #(
            .DIV_W (DIV_W)
        ) tone_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (load),
            .reload_i (reload[g]),
            .run_i    (playing),
            .tone_o   (tone_vec[g])
        );
    end

    assign tone_a_o = tone_vec[0];
    assign tone_b_o = tone_vec[1];

endmodule

// File: rtl/melody_seq_chk.sv
// Port-level protocol checks for melody_seq, bound to every instance.
module melody_seq_chk #(
    parameter int ADDR_W = 10,
    parameter int SONG_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              play_i,
    input logic [SONG_W-1:0] song_i,
    input logic              busy_mode_i,
    input logic              busy_o,
    input logic              tone_a_o,
    input logic              tone_b_o,
    input logic              mem_rd_en_o,
    input logic [ADDR_W-1:0] mem_addr_o
);

    p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!tone_a_o && !tone_b_o));

    p_table_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (play_i && song_i != '0) |=> (mem_rd_en_o && mem_addr_o == ADDR_W'($past(song_i))));

    p_single_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en_o && !play_i) |=> !mem_rd_en_o);

    p_song0_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_mode_i && !busy_o && play_i && song_i == '0) |=> !busy_o);

    p_note_min_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_mode_i && $rose(busy_o) && !play_i) |=> busy_o);

    p_song_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_mode_i && play_i && song_i != '0) |=> busy_o);

endmodule

bind melody_seq melody_seq_chk #(
    .ADDR_W (ADDR_W),
    .SONG_W (SONG_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .play_i      (play_i),
    .song_i      (song_i),
    .busy_mode_i (busy_mode_i),
    .busy_o      (busy_o),
    .tone_a_o    (tone_a_o),
    .tone_b_o    (tone_b_o),
    .mem_rd_en_o (mem_rd_en_o),
    .mem_addr_o  (mem_addr_o)
);

// File: tb/melody_seq_tb_top.sv
// Scoreboard bench: the driver derives per-note expectations from the note
// memory contents and queues them; a monitor measures busy windows and tone
// toggles at the falling edge and compares them.
module melody_seq_tb_top;

    localparam int TICK = 4;
    localparam int STEP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        play_i = 1'b0;
    logic [4:0]  song_i = '0;
    logic [3:0]  tempo_i = '0;
    logic        busy_mode_i = 1'b0;
    logic        mem_rd_en_o;
    logic [9:0]  mem_addr_o;
    logic [21:0] mem_rdata_i;
    logic        tone_a_o, tone_b_o, busy_o;

    logic [21:0] mem [1024];

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;

    always #4 clk = ~clk;   // 125 MHz

    melody_seq #(.TICK_PER_UNIT(TICK), .PITCH_STEP(STEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .play_i(play_i), .song_i(song_i),
        .tempo_i(tempo_i), .busy_mode_i(busy_mode_i),
        .mem_rd_en_o(mem_rd_en_o), .mem_addr_o(mem_addr_o),
        .mem_rdata_i(mem_rdata_i), .tone_a_o(tone_a_o),
        .tone_b_o(tone_b_o), .busy_o(busy_o)
    );

    // Synchronous note memory model.
    always_ff @(posedge clk) begin
        if (mem_rd_en_o) mem_rdata_i <= mem[mem_addr_o];
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [21:0] mk(input int a, input int b, input int beat, input bit eos);
        return {6'(a), 6'(b), 3'(beat), eos, 6'b0};
    endfunction

    function automatic int units(input int beat);
        case (beat)
            0: return 1;  1: return 2;  2: return 3;
            3: return 4;  4: return 6;  default: return 8;
        endcase
    endfunction

    function automatic int interval(input int code);
        if (code == 0) return 0;
        return STEP * (42 - ((code > 41) ? 41 : code));
    endfunction

    function automatic int toggles(input int d, input int code);
        int l = interval(code);
        return (l == 0) ? 0 : (d - 1) / l;
    endfunction

    typedef struct { int dur; int tog_a; int tog_b; bit first; } exp_note_t;
    exp_note_t exp_q[$];

    bit mon_en = 1'b0;
    bit win_open = 1'b0;
    bit prev_busy = 1'b0, prev_a = 1'b0, prev_b = 1'b0;
    int win_len = 0, win_ta = 0, win_tb = 0, gap_len = 0;
    exp_note_t cur;

    // Monitor: busy window length, tone toggles and gaps (per-note mode).
    always @(negedge clk) begin
        if (mon_en) begin
            if (busy_o && !prev_busy) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected note", 1, 0);
                end else begin
                    cur = exp_q.pop_front();
                    if (!cur.first) chk(gap_len == 1, "R6 gap between notes", gap_len, 1);
                    chk(!tone_a_o && !tone_b_o, "R5 note starts low", int'(tone_a_o | tone_b_o), 0);
                    win_open = 1'b1;
                    win_len = 1; win_ta = 0; win_tb = 0;
                end
            end else if (busy_o && win_open) begin
                win_len++;
                if (tone_a_o != prev_a) win_ta++;
                if (tone_b_o != prev_b) win_tb++;
            end else if (!busy_o && prev_busy && win_open) begin
                chk(win_len == cur.dur, "R4 note duration", win_len, cur.dur);
                chk(win_ta == cur.tog_a, "R3/R5 tone A toggles", win_ta, cur.tog_a);
                chk(win_tb == cur.tog_b, "R3/R5 tone B toggles", win_tb, cur.tog_b);
                chk(!tone_a_o && !tone_b_o, "R10 tones low in gap", int'(tone_a_o | tone_b_o), 0);
                win_open = 1'b0;
                gap_len = 1;
            end else if (!busy_o) begin
                gap_len++;
            end
        end
        prev_busy = busy_o; prev_a = tone_a_o; prev_b = tone_b_o;
    end

    // Driver: build expectations from memory, then pulse play.
    task automatic play_song(input int song, input int tempo, input bit push, output int span);
        int addr = int'(mem[song][9:0]);
        int sum = 0, n = 0;
        bit first = 1'b1;
        logic [21:0] w;
        forever begin
            exp_note_t e;
            w = mem[addr];
            e.dur = units(int'(w[9:7])) * (tempo + 1) * TICK;
            e.tog_a = toggles(e.dur, int'(w[21:16]));
            e.tog_b = toggles(e.dur, int'(w[15:10]));
            e.first = first;
            first = 1'b0;
            if (push) exp_q.push_back(e);
            sum += e.dur; n++;
            if (w[6]) break;
            addr = (addr + 1) % 1024;
        end
        span = 4 + sum + (n - 1);
        @(posedge clk); #1;
        play_i = 1'b1; song_i = 5'(song); tempo_i = 4'(tempo);
        @(posedge clk); #1;
        play_i = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (exp_q.size() != 0 || busy_o || win_open);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            chk(1'b0, "watchdog expired", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        int span, cnt;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        mem[1]  = 22'd40;  mem[2] = 22'd100; mem[3] = 22'd200; mem[31] = 22'd1022;
        mem[40] = mk(1, 41, 0, 0);  mem[41] = mk(20, 0, 3, 0);  mem[42] = mk(63, 5, 5, 1);
        mem[100] = mk(0, 0, 7, 0) | 22'h3f;  mem[101] = mk(41, 2, 2, 1);
        mem[200] = mk(41, 1, 0, 1);
        mem[1022] = mk(30, 12, 4, 0); mem[1023] = mk(3, 33, 1, 1);

        // R1: reset state.
        repeat (4) @(negedge clk);
        chk(!busy_o && !tone_a_o && !tone_b_o && !mem_rd_en_o, "R1 in reset",
            int'({busy_o, tone_a_o, tone_b_o, mem_rd_en_o}), 0);
        @(posedge clk); #1; rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy_o && !tone_a_o && !tone_b_o && !mem_rd_en_o, "R1 after reset",
            int'({busy_o, tone_a_o, tone_b_o, mem_rd_en_o}), 0);

        // Per-note scoreboard over several songs.
        mon_en = 1'b1;
        play_song(1, 5, 1'b1, span);  wait_done();
        play_song(2, 0, 1'b1, span);  wait_done();
        play_song(31, 1, 1'b1, span); wait_done();
        play_song(3, 15, 1'b1, span); wait_done();

        // R9: restart mid-note at a different song.
        mon_en = 1'b0;
        play_song(1, 5, 1'b0, span);
        do @(negedge clk); while (!busy_o);
        repeat (10) @(negedge clk);
        exp_q.delete();
        mon_en = 1'b1;
        play_song(2, 0, 1'b1, span);
        wait_done();
        chk(exp_q.size() == 0, "R9 restarted song fully played", exp_q.size(), 0);
        mon_en = 1'b0;

        // R7: per-song busy span.
        busy_mode_i = 1'b1;
        repeat (2) @(negedge clk);
        play_song(1, 5, 1'b0, span);
        cnt = 0;
        @(negedge clk);
        while (busy_o) begin cnt++; @(negedge clk); end
        chk(cnt == span, "R7 song busy span song 1", cnt, span);
        chk(!tone_a_o && !tone_b_o, "R10 tones low after song", int'(tone_a_o | tone_b_o), 0);
        play_song(31, 1, 1'b0, span);
        cnt = 0;
        @(negedge clk);
        while (busy_o) begin cnt++; @(negedge clk); end
        chk(cnt == span, "R7 song busy span song 31", cnt, span);

        // R8: song 0 ignored.
        @(posedge clk); #1; play_i = 1'b1; song_i = 5'd0;
        @(posedge clk); #1; play_i = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(!busy_o && !mem_rd_en_o, "R8 song 0 ignored", int'({busy_o, mem_rd_en_o}), 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule